// File: doc/BRIEF.md
# Serial Master Host Front End with Write-Collision Guard

This block sits between a processor's register writes and a serial bus master engine. Software writes a data buffer register to send a byte, and writes a control register whose low five bits ask the engine to start one bus operation each: start condition, repeated start, stop, receive and acknowledge. The bits above those five are ordinary control storage that the block keeps and presents to the engine.

The block keeps a single busy bit. Any accepted request sets it: a buffer write (which also starts a transmit) or a trigger write. A done pulse from the engine clears it. While busy is set, the block queues nothing. A buffer write is dropped and raises a sticky collision flag. Trigger bits are discarded, and this covers the whole time a start condition is still in progress. Software clears the collision flag by writing zero to bit 0 of a status address.

Each accepted request reaches the engine as a one-cycle strobe on a six-bit command vector. The strobe rises in the cycle after the write edge and falls one cycle later.

Top module: `ser_host_guard`

## Requirements
- R1: After reset the buffer, the upper control field, the collision flag, the busy bit and every command strobe are all zero.
- R2: A write to the buffer address while busy is zero does three things: it loads the full data word into the buffer, it pulses command bit 5 (transmit) for one cycle, and it sets busy. All of these are visible in the cycle after the write edge.
- R3: A write to the buffer address while busy is one is dropped. The buffer keeps its old value, no strobe is issued, and the collision flag is set in the next cycle.
- R4: The collision flag stays set until a write to the status address with data bit 0 equal to 0. A status write with bit 0 equal to 1 leaves the flag unchanged.
- R5: While idle, a control write whose low five bits are non-zero pulses one command bit and sets busy. The mapping is data bit 0 to start, bit 1 to repeated start, bit 2 to stop, bit 3 to receive and bit 4 to acknowledge, and each drives the command bit of the same index.
- R6: When several trigger bits are set in one write, only the lowest-numbered one is issued, so start has the highest priority and acknowledge the lowest.
- R7: A control write while busy issues no strobe and leaves busy unchanged. Its trigger bits are not remembered, so no strobe follows once the engine reports done.
- R8: The control bits above bit 4 are stored from every control write, whether the block is busy or idle.
- R9: A done pulse clears busy in the next cycle. A done pulse while idle has no effect.
- R10: A control write while idle whose low five bits are all zero issues no strobe and leaves busy at zero.
- R11: Every command strobe lasts exactly one cycle, and at most one command bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 buffer, 1 control, 2 status |
| wr_data | input | DATA_W | Write data |
| eng_done | input | 1 | Engine operation-done pulse |
| buf_q | output | DATA_W | Buffer contents |
| ctrl_hi | output | DATA_W-5 | Stored upper control bits |
| cmd_stb | output | 6 | One-cycle command strobes; bits 0..4 are the triggers, bit 5 is transmit |
| busy | output | 1 | An operation is in progress |
| collision | output | 1 | Sticky write-collision flag |

## Verification
The bench builds the block with DATA_W set to 10. This gives a five-bit upper control field, so the bench can check that upper-field writes made while busy are kept. It can also show that a buffer word wider than a byte loads whole or is left fully untouched. The default address parameters are kept, which reaches every register. The bench covers each trigger priority pair, a done pulse that lands in the same cycle as a rejected buffer write, and a done pulse while idle.

// File: rtl/ser_host_pkg.sv
package ser_host_pkg;

  localparam int TRIG_W = 5;
  localparam int CMD_W  = TRIG_W + 1;
  localparam int CMD_TX = TRIG_W;

  localparam int TRIG_START  = 0;
  localparam int TRIG_RSTART = 1;
  localparam int TRIG_STOP   = 2;
  localparam int TRIG_RCV    = 3;
  localparam int TRIG_ACK    = 4;

  // Keep only the lowest-numbered requested trigger (start wins).
  function automatic logic [TRIG_W-1:0] pick_trigger(input logic [TRIG_W-1:0] req);
    logic [TRIG_W-1:0] sel;
    sel = '0;
    for (int i = TRIG_W - 1; i >= 0; i--) begin
      if (req[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
    return sel;
  endfunction

  // Pack the trigger and transmit grants into the command vector.
  function automatic logic [CMD_W-1:0] make_cmd(input logic [TRIG_W-1:0] trig,
                                                input logic tx);
    return {tx, trig};
  endfunction

endpackage

// File: rtl/shg_busy_tracker.sv
module shg_busy_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic op_done,
  output logic busy
);

  always_ff @(posedge clk) begin
    if (!rst_n)      busy <= 1'b0;
    else if (launch) busy <= 1'b1;
    else if (op_done) busy <= 1'b0;
  end

  // R2 / R5: an accepted request always leaves the block busy
  p_launch_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // No queueing: a launch never arrives on top of a running operation
  p_launch_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);

  // R9: done clears busy, done while idle changes nothing
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !launch) |=> !busy);

endmodule

// File: rtl/shg_buf_reg.sv
module shg_buf_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_buf,
  input  logic              wr_stat,
  input  logic              stat_bit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              tx_go,
  output logic [DATA_W-1:0] buf_q,
  output logic              collision
);

  logic col_evt;
  logic col_clr;

  assign tx_go   = wr_buf & ~busy;
  assign col_evt = wr_buf & busy;
  assign col_clr = wr_stat & ~stat_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)     buf_q <= '0;
    else if (tx_go) buf_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       collision <= 1'b0;
    else if (col_evt) collision <= 1'b1;
    else if (col_clr) collision <= 1'b0;
  end

  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && !busy) |=> buf_q == $past(wr_data));

  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && busy) |=> ($stable(buf_q) && collision));

  p_sticky_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !wr_stat) |=> collision);

  p_clear_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !stat_bit && !wr_buf) |=> !collision);

endmodule

// File: rtl/shg_ctrl_reg.sv
module shg_ctrl_reg
  import ser_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ctrl,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     busy,
  output logic [TRIG_W-1:0]        trig_go,
  output logic [DATA_W-TRIG_W-1:0] ctrl_hi
);

  localparam int HI_W = DATA_W - TRIG_W;

  logic [TRIG_W-1:0] trig_req;

  assign trig_req = wr_data[TRIG_W-1:0] & {TRIG_W{wr_ctrl & ~busy}};
  assign trig_go  = pick_trigger(trig_req);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_hi <= '0;
    else if (wr_ctrl) ctrl_hi <= wr_data[DATA_W-1:TRIG_W];
  end

  p_hi_writable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_hi == $past(wr_data[DATA_W-1:TRIG_W]));

  p_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_hi));

  initial begin
    assert (HI_W >= 1);
  end

endmodule

// File: rtl/ser_host_guard.sv
module ser_host_guard
  import ser_host_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] ADDR_BUF  = 'd0,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 'd1,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 'd2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     eng_done,
  output logic [DATA_W-1:0]        buf_q,
  output logic [DATA_W-TRIG_W-1:0] ctrl_hi,
  output logic [CMD_W-1:0]         cmd_stb,
  output logic                     busy,
  output logic                     collision
);

  logic              wr_buf;
  logic              wr_ctrl;
  logic              wr_stat;
  logic              tx_go;
  logic [TRIG_W-1:0] trig_go;
  logic              launch;

  assign wr_buf  = wr_en && (wr_addr == ADDR_BUF);
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);
  assign launch  = tx_go | (|trig_go);

  shg_buf_reg #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_buf    (wr_buf),
    .wr_stat   (wr_stat),
    .stat_bit  (wr_data[0]),
    .wr_data   (wr_data),
    .busy      (busy),
    .tx_go     (tx_go),
    .buf_q     (buf_q),
    .collision (collision)
  );

  shg_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .busy    (busy),
    .trig_go (trig_go),
    .ctrl_hi (ctrl_hi)
  );

  shg_busy_tracker u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .op_done (eng_done),
    .busy    (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_stb <= '0;
    else        cmd_stb <= make_cmd(trig_go, tx_go);
  end

  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_stb) |=> cmd_stb == '0);

  p_masked_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ctrl || wr_buf) && busy) |=> cmd_stb == '0);

  p_start_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !busy && wr_data[TRIG_START]) |=> cmd_stb[TRIG_START]);

  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_stb) |-> busy || $past(eng_done));

endmodule

// File: tb/ser_host_guard_tb_top.sv
module ser_host_guard_tb_top;

  localparam int DW = 10;
  localparam int HW = DW - 5;

  typedef struct {
    logic [5:0]    stb;
    logic          busy;
    logic          col;
    logic [DW-1:0] bufv;
    logic [HW-1:0] hi;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          eng_done = 1'b0;
  logic [DW-1:0] buf_q;
  logic [HW-1:0] ctrl_hi;
  logic [5:0]    cmd_stb;
  logic          busy;
  logic          collision;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  exp_t q[$];

  logic [DW-1:0] m_buf = '0;
  logic [HW-1:0] m_hi  = '0;
  logic          m_col = 1'b0;
  logic          m_busy = 1'b0;

  always #10 clk = ~clk;

  ser_host_guard #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_done(eng_done), .buf_q(buf_q),
    .ctrl_hi(ctrl_hi), .cmd_stb(cmd_stb), .busy(busy), .collision(collision)
  );

  // Driver: apply one cycle of stimulus and predict the state after the edge.
  task automatic step(input logic we, input logic [1:0] a, input logic [DW-1:0] d,
                      input logic dn, input string tag);
    exp_t e;
    logic [4:0] t;
    logic go;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; eng_done = dn;
    e.stb = '0;
    go = 1'b0;
    if (we && a == 2'd0) begin
      if (m_busy) m_col = 1'b1;
      else begin m_buf = d; e.stb[5] = 1'b1; go = 1'b1; end
    end
    if (we && a == 2'd1) begin
      m_hi = d[DW-1:5];
      t = d[4:0];
      if (!m_busy && t != 0) begin e.stb[4:0] = t & (~t + 5'd1); go = 1'b1; end
    end
    if (we && a == 2'd2 && !d[0]) m_col = 1'b0;
    if (go) m_busy = 1'b1;
    else if (dn) m_busy = 1'b0;
    e.busy = m_busy; e.col = m_col; e.bufv = m_buf; e.hi = m_hi; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd3, '0, 1'b0, tag);
  endtask

  task automatic done(input string tag);
    step(1'b0, 2'd3, '0, 1'b1, tag);
  endtask

  // Monitor: pop each expected item and compare after the edge settles.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (cmd_stb !== e.stb || busy !== e.busy || collision !== e.col ||
            buf_q !== e.bufv || ctrl_hi !== e.hi) begin
          fails++;
          $display("FAIL %s: got stb=%b busy=%b col=%b buf=%h hi=%h exp stb=%b busy=%b col=%b buf=%h hi=%h",
                   e.tag, cmd_stb, busy, collision, buf_q, ctrl_hi,
                   e.stb, e.busy, e.col, e.bufv, e.hi);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (buf_q !== '0 || ctrl_hi !== '0 || cmd_stb !== '0 || busy !== 1'b0 || collision !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got buf=%h hi=%h stb=%b busy=%b col=%b exp all zero",
               buf_q, ctrl_hi, cmd_stb, busy, collision);
    end

    step(1'b1, 2'd0, 10'h02A, 1'b0, "R2 idle buffer write");
    idle("R11 transmit strobe ends");
    step(1'b1, 2'd0, 10'h155, 1'b0, "R3 buffer write while busy");
    step(1'b1, 2'd1, 10'h3E1, 1'b0, "R7 R8 trigger while busy, upper kept");
    done("R9 done clears busy");
    idle("R7 no queued trigger after done");
    done("R9 done while idle");
    step(1'b1, 2'd2, 10'h001, 1'b0, "R4 status bit0=1 keeps flag");
    step(1'b1, 2'd2, 10'h000, 1'b0, "R4 status bit0=0 clears flag");
    step(1'b1, 2'd1, 10'h001, 1'b0, "R5 start trigger");
    step(1'b1, 2'd0, 10'h0FF, 1'b0, "R3 buffer write during start");
    step(1'b1, 2'd1, 10'h022, 1'b0, "R7 trigger during start");
    done("R9 start done");
    step(1'b1, 2'd1, 10'h01C, 1'b0, "R6 stop beats receive and ack");
    done("R9 stop done");
    step(1'b1, 2'd1, 10'h018, 1'b0, "R6 receive beats ack");
    done("R9 receive done");
    step(1'b1, 2'd1, 10'h010, 1'b0, "R5 ack trigger");
    done("R9 ack done");
    step(1'b1, 2'd1, 10'h003, 1'b0, "R6 start beats repeated start");
    done("R9 done");
    step(1'b1, 2'd1, 10'h002, 1'b0, "R5 repeated start trigger");
    idle("R11 trigger strobe ends");
    done("R9 done");
    step(1'b1, 2'd1, 10'h140, 1'b0, "R10 R8 no trigger bits");
    idle("R10 stays idle");
    step(1'b1, 2'd0, 10'h3C3, 1'b0, "R2 wide buffer load");
    step(1'b1, 2'd0, 10'h001, 1'b1, "R3 rejected write with done");
    step(1'b1, 2'd0, 10'h201, 1'b0, "R2 load after done");
    done("R9 final done");
    step(1'b1, 2'd2, 10'h3FE, 1'b0, "R4 clear with other bits set");
    idle("R1 settle");

    while (q.size() > 0) @(posedge clk);
    #5;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule